// File: doc/BRIEF.md
# Dual-Mode 16-bit Timer/Counter

This block is a 16-bit up-counter held as two separately writable bytes. It can time (one step per machine cycle, which lasts twelve clocks) or count events (one step per falling edge seen on a synchronized external event input). Software programs it through a small register port. It chooses one of two count layouts. In the wide layout both bytes form a single 16-bit count. In the reload layout only the low byte counts, and on rollover it is refilled from the high byte, which gives a programmable period without software help.

Every rollover sets a sticky overflow flag. It also raises a one-clock overflow pulse, which a neighbouring serial port can use as a baud tick. The count only moves while the run bit is set.

Top module: `tmr16_top`

## Requirements
- R1: After reset the low byte, high byte, run bit, layout bit, source bit and overflow flag are all zero, and the overflow pulse is low.
- R2: A write with `wr_sel` 0 loads the low byte, 1 the high byte, and 2 the control byte. Reads use the same encoding on `rd_sel`, and `rd_sel` 3 reads zero. Control bits: bit 0 run, bit 1 layout (0 = 16-bit, 1 = 8-bit reload), bit 2 source (0 = machine cycles, 1 = events), bit 3 overflow flag. Bits 7..4 read zero.
- R3: While the run bit is clear, neither byte changes unless software writes it, whatever the event input or the clock does.
- R4: In timing operation the count advances once every 12 clocks. The machine-cycle divider restarts when counting starts, so the first step lands on the 12th clock edge after the edge that set the run bit. The event input has no effect in this operation.
- R5: In event operation the count advances once for each 1-to-0 transition of the event input, after a two-stage synchronizer. A 0-to-1 transition alone does not advance it.
- R6: In 16-bit layout the pair counts up from the loaded value. The step from FFFF wraps to 0000 and sets the overflow flag.
- R7: In 8-bit reload layout only the low byte counts. The step from FF loads the low byte with the high byte, leaves the high byte unchanged and sets the overflow flag.
- R8: The overflow flag stays set until software writes 0 to control bit 3. If that write and a rollover fall on the same clock edge, the flag ends up set.
- R9: Each rollover produces exactly one overflow pulse, one clock wide, in the cycle the flag becomes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low, 1 high, 2 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target: 0 low, 1 high, 2 control, 3 zero |
| rd_data | output | 8 | Read data (combinational) |
| evt_in | input | 1 | Asynchronous external event input |
| ovf_pulse | output | 1 | One-clock pulse per rollover |

## Verification
The in-RTL assertions check four things on every cycle:
- a stopped count stays frozen when no write arrives, and the flag stays set until a control write clears it;
- each overflow pulse coincides with a set flag and lasts one clock;
- each rollover leaves the expected value, 0000 in 16-bit layout and the high byte copied into the low byte in reload layout;
- divider ticks and detected event edges never repeat on back-to-back cycles.

The divide-by-twelve step timing, the counts reached over several loads in both layouts, the event-edge polarity, the register readback and the collision between a flag-clearing write and a rollover are only shown by the bench's scenarios.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W = 8;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_SRC  = 2;
    localparam int CTRL_FLAG = 3;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              run;
        logic              mode;   // 0: 16-bit, 1: 8-bit reload
        logic              src;    // 0: machine cycles, 1: events
        logic              flag;
        logic              ovf;
    } tmr_state_t;

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    generate
        if (DIV > 1) begin : g_gap
            assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tmr16_evt_edge.sv
module tmr16_evt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic fall
);
    logic [STAGES:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-1:0], evt_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // oldest stage high, next newer stage low: a 1-to-0 transition
    assign fall = sync_q[STAGES] & ~sync_q[STAGES-1];

    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tick,
    input  logic              fall,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              run_o,
    output logic              src_o,
    output logic              ovf_o
);
    tmr_state_t st_d, st_q;
    logic adv;
    logic ovf_evt;
    logic [2*BYTE_W-1:0] pair;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        ovf_evt  = 1'b0;
        pair     = {st_q.hi, st_q.lo};
        adv      = st_q.run && (st_q.src ? fall : tick);

        if (adv) begin
            if (!st_q.mode) begin
                {st_d.hi, st_d.lo} = pair + 1'b1;
                ovf_evt = &pair;
            end else if (&st_q.lo) begin
                st_d.lo = st_q.hi;
                ovf_evt = 1'b1;
            end else begin
                st_d.lo = st_q.lo + 1'b1;
            end
        end

        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_LO:   st_d.lo = wr_data;
                SEL_HI:   st_d.hi = wr_data;
                SEL_CTRL: begin
                    st_d.run  = wr_data[CTRL_RUN];
                    st_d.mode = wr_data[CTRL_MODE];
                    st_d.src  = wr_data[CTRL_SRC];
                    st_d.flag = wr_data[CTRL_FLAG];
                end
                default: ;
            endcase
        end

        // hardware set outranks a same-cycle software clear
        if (ovf_evt) begin
            st_d.flag = 1'b1;
            st_d.ovf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_o   = st_q.lo;
    assign hi_o   = st_q.hi;
    assign ctrl_o = {{(BYTE_W-4){1'b0}}, st_q.flag, st_q.src, st_q.mode, st_q.run};
    assign run_o  = st_q.run;
    assign src_o  = st_q.src;
    assign ovf_o  = st_q.ovf;

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_en) |=> $stable({st_q.hi, st_q.lo}));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(wr_en && wr_sel == SEL_CTRL)) |=> st_q.flag);

    assert_pulse_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> st_q.flag);

    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> !st_q.ovf);

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !st_q.mode && !$past(wr_en)) |-> ({st_q.hi, st_q.lo} == '0));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && st_q.mode && !$past(wr_en)) |-> (st_q.lo == st_q.hi));

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
    import tmr16_pkg::*;
#(
    parameter int DIV         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              evt_in,
    output logic              ovf_pulse
);
    logic tick, fall, run, src;
    logic [BYTE_W-1:0] lo, hi, ctrl;

    tmr16_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run & ~src),
        .tick (tick)
    );

    tmr16_evt_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_in(evt_in),
        .fall  (fall)
    );

    tmr16_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .tick   (tick),
        .fall   (fall),
        .lo_o   (lo),
        .hi_o   (hi),
        .ctrl_o (ctrl),
        .run_o  (run),
        .src_o  (src),
        .ovf_o  (ovf_pulse)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_LO:   rd_data = lo;
            SEL_HI:   rd_data = hi;
            SEL_CTRL: rd_data = ctrl;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: tb/tmr16_top_tb.sv
module tmr16_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       evt_in = 1'b0;
    logic       ovf_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int ovf_seen = 0;
    logic prev_ovf = 1'b0;
    logic wide_seen = 1'b0;

    always #10 clk = ~clk;

    tmr16_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_in(evt_in), .ovf_pulse(ovf_pulse)
    );

    always @(negedge clk) begin
        if (ovf_pulse) begin
            ovf_seen = ovf_seen + 1;
            if (prev_ovf) wide_seen = 1'b1;
        end
        prev_ovf = ovf_pulse;
    end

    // mode, lo, hi, machine cycles, expected lo, hi, flag, pulses
    typedef struct packed {
        logic       mode;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] steps;
        logic [7:0] elo;
        logic [7:0] ehi;
        logic       eflag;
        logic [3:0] novf;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 8'h10, 8'h00, 8'd5, 8'h15, 8'h00, 1'b0, 4'd0},
        '{1'b0, 8'hFF, 8'h00, 8'd1, 8'h00, 8'h01, 1'b0, 4'd0},
        '{1'b0, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1, 4'd1},
        '{1'b1, 8'hFD, 8'h80, 8'd4, 8'h81, 8'h80, 1'b1, 4'd1},
        '{1'b1, 8'h00, 8'h00, 8'd2, 8'h02, 8'h00, 1'b0, 4'd0},
        '{1'b1, 8'hFF, 8'hFF, 8'd3, 8'hFF, 8'hFF, 1'b1, 4'd3}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at or just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic pulse_evt();
        evt_in = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] a, b, c, d;
        int base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, a); rd(2'd1, b); rd(2'd2, c);
        chk("R1 low byte", {8'h0, a}, 16'h0);
        chk("R1 high byte", {8'h0, b}, 16'h0);
        chk("R1 control", {8'h0, c}, 16'h0);
        chk("R1 pulse", {15'h0, ovf_pulse}, 16'h0);

        // R2 register access
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hFE);
        rd(2'd0, a); rd(2'd1, b); rd(2'd2, c); rd(2'd3, d);
        chk("R2 low readback", {8'h0, a}, 16'h00A5);
        chk("R2 high readback", {8'h0, b}, 16'h003C);
        chk("R2 control readback", {8'h0, c}, 16'h000E);
        chk("R2 unused select", {8'h0, d}, 16'h0000);
        wr(2'd2, 8'h00);

        // R3 stopped: timer source and event source
        wr(2'd0, 8'h34); wr(2'd1, 8'h12);
        repeat (40) @(negedge clk);
        wr(2'd2, 8'h04);
        for (int i = 0; i < 3; i++) pulse_evt();
        rd(2'd0, a); rd(2'd1, b);
        chk("R3 frozen while stopped", {b, a}, 16'h1234);

        // vector table: timing operation, both layouts (R4 R6 R7 R8 R9)
        for (int v = 0; v < 6; v++) begin
            wr(2'd0, VEC[v].lo);
            wr(2'd1, VEC[v].hi);
            wr(2'd2, {6'b0, VEC[v].mode, 1'b0});
            #1;
            base = ovf_seen;
            wr(2'd2, {6'b0, VEC[v].mode, 1'b1});
            repeat (12 * int'(VEC[v].steps)) @(negedge clk);
            rd(2'd0, a); rd(2'd1, b); rd(2'd2, c);
            chk($sformatf("R4 R6 R7 vec%0d count", v), {b, a}, {VEC[v].ehi, VEC[v].elo});
            chk($sformatf("R8 vec%0d flag", v), {15'h0, c[3]}, {15'h0, VEC[v].eflag});
            chk($sformatf("R9 vec%0d pulses", v), 16'(ovf_seen - base), {12'h0, VEC[v].novf});
            wr(2'd2, 8'h00);
        end

        // R4 first step boundary, event input ignored in timing operation
        wr(2'd0, 8'h40); wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        for (int i = 0; i < 10; i++) begin
            evt_in = ~evt_in;
            @(negedge clk);
        end
        evt_in = 1'b0;
        @(negedge clk);
        rd(2'd0, a);
        chk("R4 no step before 12th edge", {8'h0, a}, 16'h0040);
        @(negedge clk);
        rd(2'd0, a);
        chk("R4 step on 12th edge", {8'h0, a}, 16'h0041);
        wr(2'd2, 8'h00);

        // R5 event operation: falling edges count, rising edge alone does not
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, 8'h05);
        for (int i = 0; i < 5; i++) pulse_evt();
        rd(2'd0, a);
        chk("R5 five falling edges", {8'h0, a}, 16'h0005);
        evt_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, a);
        chk("R5 rising edge ignored", {8'h0, a}, 16'h0005);
        evt_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, a);
        chk("R5 following fall counted", {8'h0, a}, 16'h0006);

        // R6 16-bit rollover in event operation
        wr(2'd2, 8'h04);
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h05);
        pulse_evt();
        rd(2'd0, a); rd(2'd1, b); rd(2'd2, c);
        chk("R6 event wrap", {b, a}, 16'h0000);
        chk("R6 event wrap flag", {15'h0, c[3]}, 16'h0001);

        // R8 clear by software write of 0
        wr(2'd2, 8'h04);
        rd(2'd2, c);
        chk("R8 flag cleared by write", {15'h0, c[3]}, 16'h0000);

        // R8 collision: software clear on the same edge as a rollover
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        repeat (11) @(negedge clk);
        wr(2'd2, 8'h01);
        rd(2'd0, a); rd(2'd1, b); rd(2'd2, c);
        chk("R8 collision count wrapped", {b, a}, 16'h0000);
        chk("R8 hardware set wins", {15'h0, c[3]}, 16'h0001);
        wr(2'd2, 8'h00);

        // R9 pulse width across the whole run
        chk("R9 pulse one clock wide", {15'h0, wide_seen}, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule